// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

This block is the data-moving half of a single DMA channel. It keeps the channel's five words of state (source address, destination address, next-descriptor pointer, control word and configuration word). Each time an external arbiter grants it, it moves one element over a simple memory master port. An element is gathered from the source in source-width reads, then scattered to the destination in destination-width writes, with optional address increments. The block then decrements the element count that sits in the low bits of the control word.

When the count runs out, the channel either follows its linked list or switches itself off. To follow the list, it fetches a four-word descriptor from memory into its own registers. If the pointer is zero, it clears its enable bit. In both cases, a one-cycle terminal-count pulse marks the end of the transfer when the control word then in effect asks for it. A host writes the registers through a small select/data port. These writes are held off while an element is in flight. All five registers are visible on output ports.

Top module: `lldma_chan`

## Requirements
- R1: After reset all five registers read zero, and `busy`, `tc_pulse` and `mem_req_valid` are low while `host_ready` is high.
- R2: A host write with `host_sel` 0, 1, 2, 3 or 4 loads source, destination, list pointer, control or configuration respectively. It is accepted only when `host_ready` (not busy) is high. Writes with any other select, or made while busy, change no register.
- R3: A grant starts an element only when configuration bit 0 is 1 and the count (control bits 11:0) is nonzero; otherwise it is ignored. A host write in the grant cycle lands first, so the element uses the new addresses.
- R4: The source width is 1 shifted left by control bits 20:18, and the destination width is 1 shifted left by control bits 23:21, both in bytes. Codes above 2 are clamped to 4 bytes. `mem_req_size` carries the log2 byte count.
- R5: Reads of source width from the source address repeat until a destination width of bytes is staged, with at least one read. Each read's low bytes land at the next staging offset. When control bit 26 is set, the source address grows by the source width after each read.
- R6: Writes of destination width go to destination address plus offsets 0, dw, 2·dw… until the larger width is covered. Each write's low data bytes are the staged bytes from that offset. When control bit 27 is set, the destination address grows by the source width after each write.
- R7: After each element the count drops by one, and control bits 31:12 are unchanged.
- R8: When the count reaches zero with a nonzero list pointer, four word-size reads at pointer+0, +4, +12 and +8, issued in that order, load source, destination, control and the new pointer. The words are little-endian.
- R9: When the count reaches zero with a zero list pointer, configuration bit 0 is cleared and its other bits are kept.
- R10: `tc_pulse` is high for one cycle at the end of an element that finishes the count, if bit 31 of the control word in effect at that point (the fetched one after a descriptor load) is set. It never pulses for an element that leaves a nonzero count.
- R11: A request holds its valid and its fields until accepted, and only one access is outstanding. A read ends when `mem_rsp_valid` returns data; a write ends at its handshake.
- R12: `busy` rises in the cycle after an accepted grant and stays high until the element and any descriptor fetch are complete. Any terminal-count pulse falls in the last busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 3 | Register select (0 src, 1 dst, 2 list pointer, 3 control, 4 configuration) |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | High when a host write is accepted |
| grant | input | 1 | Arbiter grant for one element |
| busy | output | 1 | Element or descriptor fetch in progress |
| tc_pulse | output | 1 | Terminal-count event, one cycle |
| src_addr | output | ADDR_W | Source address register |
| dst_addr | output | ADDR_W | Destination address register |
| lli_addr | output | ADDR_W | Next-descriptor pointer register |
| ctrl_word | output | 32 | Control register |
| cfg_word | output | 32 | Configuration register |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | ADDR_W | Request byte address |
| mem_req_size | output | 2 | log2 of access bytes |
| mem_req_wdata | output | 32 | Write data, low bytes significant |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data, low bytes significant |

## Verification
A host register write and an arbiter grant can land in the same idle cycle. The write must take effect before the element's first request goes out. The bench drives both strobes in one cycle with a fresh source address and judges the outcome by the address of the first memory read. A second collision is a host write attempted mid-element. It is judged by `host_ready` being low at that moment and by the list-pointer register reading unchanged once `busy` falls.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

  localparam int CNT_W   = 12;
  localparam int SW_LSB  = 18;
  localparam int DW_LSB  = 21;
  localparam int SI_BIT  = 26;
  localparam int DI_BIT  = 27;
  localparam int TC_BIT  = 31;
  localparam int EN_BIT  = 0;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_RDW, S_WR, S_CNT, S_FET, S_FETW, S_FIN
  } seq_st_t;

  // width code -> clamped log2 size (max 4 bytes)
  function automatic logic [1:0] clamp_code(input logic [2:0] c);
    return (c > 3'd2) ? 2'd2 : c[1:0];
  endfunction

  function automatic logic [2:0] code_bytes(input logic [1:0] c);
    return 3'd1 << c;
  endfunction

  // descriptor word offsets in fetch order: src, dst, ctrl, next
  function automatic logic [3:0] desc_off(input logic [1:0] i);
    case (i)
      2'd0:    return 4'd0;
      2'd1:    return 4'd4;
      2'd2:    return 4'd12;
      default: return 4'd8;
    endcase
  endfunction

  // place n low bytes of data into stage starting at byte off
  function automatic logic [31:0] merge_bytes(input logic [31:0] stage,
                                              input logic [31:0] data,
                                              input logic [2:0]  off,
                                              input logic [2:0]  n);
    logic [31:0] r;
    r = stage;
    for (int i = 0; i < 4; i++) begin
      if (i >= int'(off) && i < int'(off) + int'(n))
        r[8*i +: 8] = data[8*(i-int'(off)) +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/lldma_regs.sv
module lldma_regs
  import lldma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [2:0]        host_sel,
  input  logic [31:0]       host_wdata,
  input  logic              busy,
  input  logic              upd_src,
  input  logic [ADDR_W-1:0] upd_src_val,
  input  logic              upd_dst,
  input  logic [ADDR_W-1:0] upd_dst_val,
  input  logic              upd_ctrl,
  input  logic [31:0]       upd_ctrl_val,
  input  logic              upd_lli,
  input  logic [ADDR_W-1:0] upd_lli_val,
  input  logic              cnt_dec,
  input  logic              clr_en,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [ADDR_W-1:0] lli_q,
  output logic [31:0]       ctrl_q,
  output logic [31:0]       cfg_q
);

  logic host_acc;
  assign host_acc = host_we && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      lli_q  <= '0;
      ctrl_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (host_acc) begin
        case (host_sel)
          3'd0: src_q  <= ADDR_W'(host_wdata);
          3'd1: dst_q  <= ADDR_W'(host_wdata);
          3'd2: lli_q  <= ADDR_W'(host_wdata);
          3'd3: ctrl_q <= host_wdata;
          3'd4: cfg_q  <= host_wdata;
          default: ;
        endcase
      end
      if (upd_src) src_q <= upd_src_val;
      if (upd_dst) dst_q <= upd_dst_val;
      if (upd_lli) lli_q <= upd_lli_val;
      if (upd_ctrl)
        ctrl_q <= upd_ctrl_val;
      else if (cnt_dec)
        ctrl_q[CNT_W-1:0] <= ctrl_q[CNT_W-1:0] - 1'b1;
      if (clr_en) cfg_q[EN_BIT] <= 1'b0;
    end
  end

  // R7: the sequencer never decrements an exhausted count
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_dec |-> ctrl_q[CNT_W-1:0] != '0);

  // R7: upper control bits survive a decrement
  p_keep_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_dec && !upd_ctrl |=> ctrl_q[31:CNT_W] == $past(ctrl_q[31:CNT_W]));

  // R2: a host write while busy leaves the list pointer alone
  p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && host_we && host_sel == 3'd2 && !upd_lli |=> lli_q == $past(lli_q));

endmodule

// File: rtl/lldma_seq.sv
module lldma_seq
  import lldma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant,
  input  logic              cfg_en,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [2:0]        sw_code,
  input  logic [2:0]        dw_code,
  input  logic              src_inc,
  input  logic              dst_inc,
  input  logic              tc_en,
  input  logic [ADDR_W-1:0] src_q,
  input  logic [ADDR_W-1:0] dst_q,
  input  logic [ADDR_W-1:0] lli_q,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [1:0]        mem_req_size,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  output logic              busy,
  output logic              tc_pulse,
  output logic              upd_src,
  output logic [ADDR_W-1:0] upd_src_val,
  output logic              upd_dst,
  output logic [ADDR_W-1:0] upd_dst_val,
  output logic              upd_ctrl,
  output logic [31:0]       upd_ctrl_val,
  output logic              upd_lli,
  output logic [ADDR_W-1:0] upd_lli_val,
  output logic              cnt_dec,
  output logic              clr_en
);

  seq_st_t     state;
  logic [2:0]  rd_off, wr_off;
  logic [31:0] stage;
  logic [1:0]  fidx;

  logic [1:0]  sw_c, dw_c;
  logic [2:0]  sw_b, dw_b, xs_b;
  logic        start, rd_done, wr_done, fet_done, last_elem;
  logic [3:0]  rd_next, wr_next;

  assign sw_c = clamp_code(sw_code);
  assign dw_c = clamp_code(dw_code);
  assign sw_b = code_bytes(sw_c);
  assign dw_b = code_bytes(dw_c);
  assign xs_b = (sw_b > dw_b) ? sw_b : dw_b;

  // named internal events
  assign start     = (state == S_IDLE) && grant && cfg_en && (cnt != '0);
  assign rd_done   = (state == S_RDW) && mem_rsp_valid;
  assign wr_done   = (state == S_WR) && mem_req_ready;
  assign fet_done  = (state == S_FETW) && mem_rsp_valid;
  assign last_elem = (cnt == CNT_W'(1));
  assign rd_next   = {1'b0, rd_off} + {1'b0, sw_b};
  assign wr_next   = {1'b0, wr_off} + {1'b0, dw_b};

  always_comb begin
    mem_req_valid = (state == S_RD) || (state == S_WR) || (state == S_FET);
    mem_req_write = (state == S_WR);
    mem_req_wdata = stage >> {wr_off, 3'b000};
    case (state)
      S_WR:    begin mem_req_addr = dst_q + ADDR_W'(wr_off);       mem_req_size = dw_c;  end
      S_FET:   begin mem_req_addr = lli_q + ADDR_W'(desc_off(fidx)); mem_req_size = 2'd2; end
      default: begin mem_req_addr = src_q;                         mem_req_size = sw_c;  end
    endcase
  end

  assign upd_src      = (rd_done && src_inc) || (fet_done && fidx == 2'd0);
  assign upd_src_val  = fet_done ? ADDR_W'(mem_rsp_rdata) : src_q + ADDR_W'(sw_b);
  assign upd_dst      = (wr_done && dst_inc) || (fet_done && fidx == 2'd1);
  assign upd_dst_val  = fet_done ? ADDR_W'(mem_rsp_rdata) : dst_q + ADDR_W'(sw_b);
  assign upd_ctrl     = fet_done && fidx == 2'd2;
  assign upd_ctrl_val = mem_rsp_rdata;
  assign upd_lli      = fet_done && fidx == 2'd3;
  assign upd_lli_val  = ADDR_W'(mem_rsp_rdata);
  assign cnt_dec      = (state == S_CNT);
  assign clr_en       = (state == S_CNT) && last_elem && (lli_q == '0);
  assign busy         = (state != S_IDLE);
  assign tc_pulse     = (state == S_FIN) && tc_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      rd_off <= '0;
      wr_off <= '0;
      stage  <= '0;
      fidx   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state  <= S_RD;
          rd_off <= '0;
          wr_off <= '0;
          stage  <= '0;
        end
        S_RD:  if (mem_req_ready) state <= S_RDW;
        S_RDW: if (rd_done) begin
          stage  <= merge_bytes(stage, mem_rsp_rdata, rd_off, sw_b);
          rd_off <= rd_next[2:0];
          state  <= (rd_next >= {1'b0, dw_b}) ? S_WR : S_RD;
        end
        S_WR: if (wr_done) begin
          wr_off <= wr_next[2:0];
          if (wr_next >= {1'b0, xs_b}) state <= S_CNT;
        end
        S_CNT: begin
          fidx <= '0;
          if (!last_elem)          state <= S_IDLE;
          else if (lli_q != '0)    state <= S_FET;
          else                     state <= S_FIN;
        end
        S_FET:  if (mem_req_ready) state <= S_FETW;
        S_FETW: if (fet_done) begin
          fidx  <= fidx + 2'd1;
          state <= (fidx == 2'd3) ? S_FIN : S_FET;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11: a pending request keeps its fields until accepted
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
                                        && $stable(mem_req_write) && $stable(mem_req_size));

  // R4: access size never exceeds four bytes
  p_size_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_size <= 2'd2);

  // R3: busy only begins after an enabled grant
  p_start_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(grant) && $past(cfg_en));

  // R10: terminal-count pulse only inside an element
  p_tc_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> busy);

  // R12: the pulse marks the final busy cycle
  p_tc_last_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> !busy);

endmodule

// File: rtl/lldma_chan.sv
module lldma_chan
  import lldma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [2:0]        host_sel,
  input  logic [31:0]       host_wdata,
  output logic              host_ready,
  input  logic              grant,
  output logic              busy,
  output logic              tc_pulse,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [ADDR_W-1:0] lli_addr,
  output logic [31:0]       ctrl_word,
  output logic [31:0]       cfg_word,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [1:0]        mem_req_size,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata
);

  logic              upd_src, upd_dst, upd_ctrl, upd_lli, cnt_dec, clr_en;
  logic [ADDR_W-1:0] upd_src_val, upd_dst_val, upd_lli_val;
  logic [31:0]       upd_ctrl_val;

  assign host_ready = !busy;

  lldma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .host_we, .host_sel, .host_wdata, .busy,
    .upd_src, .upd_src_val, .upd_dst, .upd_dst_val,
    .upd_ctrl, .upd_ctrl_val, .upd_lli, .upd_lli_val,
    .cnt_dec, .clr_en,
    .src_q(src_addr), .dst_q(dst_addr), .lli_q(lli_addr),
    .ctrl_q(ctrl_word), .cfg_q(cfg_word)
  );

  lldma_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk, .rst_n, .grant,
    .cfg_en (cfg_word[EN_BIT]),
    .cnt    (ctrl_word[CNT_W-1:0]),
    .sw_code(ctrl_word[SW_LSB +: 3]),
    .dw_code(ctrl_word[DW_LSB +: 3]),
    .src_inc(ctrl_word[SI_BIT]),
    .dst_inc(ctrl_word[DI_BIT]),
    .tc_en  (ctrl_word[TC_BIT]),
    .src_q(src_addr), .dst_q(dst_addr), .lli_q(lli_addr),
    .mem_req_valid, .mem_req_ready, .mem_req_write, .mem_req_addr,
    .mem_req_size, .mem_req_wdata, .mem_rsp_valid, .mem_rsp_rdata,
    .busy, .tc_pulse,
    .upd_src, .upd_src_val, .upd_dst, .upd_dst_val,
    .upd_ctrl, .upd_ctrl_val, .upd_lli, .upd_lli_val,
    .cnt_dec, .clr_en
  );

endmodule

// File: tb/lldma_chan_bench.sv
`timescale 1ns/1ps
module lldma_chan_bench;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        host_we = 1'b0, grant = 1'b0;
  logic [2:0]  host_sel = '0;
  logic [31:0] host_wdata = '0;
  logic        host_ready, busy, tc_pulse;
  logic [31:0] src_addr, dst_addr, lli_addr, ctrl_word, cfg_word;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [31:0] mem_rsp_rdata = '0;
  logic [1:0]  mem_req_size;

  always #2.5 clk = ~clk;

  lldma_chan u_lldma_chan (.*);

  function automatic logic [31:0] mk_ctrl(input logic tc, input logic di, input logic si,
                                          input logic [2:0] dw, input logic [2:0] sw,
                                          input logic [11:0] cnt);
    return {tc, 3'b0, di, si, 2'b0, dw, sw, 6'b0, cnt};
  endfunction

  localparam logic [31:0] DESC_CTRL = {1'b1, 3'b0, 1'b1, 1'b1, 2'b0, 3'd2, 3'd2, 6'b0, 12'd1};

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    case (a[7:0])
      8'h40: return 32'h20;
      8'h44: return 32'hA0;
      8'h48: return 32'h0;
      8'h4C: return DESC_CTRL;
      default: return {a[7:0] + 8'd3, a[7:0] + 8'd2, a[7:0] + 8'd1, a[7:0]};
    endcase
  endfunction

  function automatic logic [31:0] size_mask(input logic [1:0] s);
    return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // memory model and logs
  logic [31:0] wr_addr [0:255];
  logic [31:0] wr_data [0:255];
  logic [1:0]  wr_size [0:255];
  logic [31:0] rd_addr [0:255];
  logic [1:0]  rd_size [0:255];
  int nwr = 0, nrd = 0, ntc = 0;
  logic [1:0] cyc = '0;

  always @(posedge clk) begin
    cyc           <= cyc + 2'd1;
    mem_req_ready <= (cyc != 2'd0);
    mem_rsp_valid <= 1'b0;
    if (rst_n && tc_pulse) ntc <= ntc + 1;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        wr_addr[nwr[7:0]] <= mem_req_addr;
        wr_data[nwr[7:0]] <= mem_req_wdata & size_mask(mem_req_size);
        wr_size[nwr[7:0]] <= mem_req_size;
        nwr <= nwr + 1;
      end else begin
        rd_addr[nrd[7:0]] <= mem_req_addr;
        rd_size[nrd[7:0]] <= mem_req_size;
        nrd <= nrd + 1;
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem_word(mem_req_addr);
      end
    end
  end

  int nchk = 0, nfail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] sel, input logic [31:0] val);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = val;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic do_grant();
    @(negedge clk); grant = 1'b1;
    @(negedge clk); grant = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 300) begin @(negedge clk); n++; end
    if (busy) begin
      nchk++; nfail++;
      $display("FAIL R12 watchdog actual=busy expected=idle");
    end
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l,
                       input logic [31:0] c, input logic [31:0] f);
    host_wr(3'd0, s); host_wr(3'd1, d); host_wr(3'd2, l);
    host_wr(3'd3, c); host_wr(3'd4, f);
  endtask

  typedef struct packed {
    logic [2:0]  sw;
    logic [2:0]  dw;
    logic        si;
    logic        di;
    logic        tc;
    logic [7:0]  e_src;
    logic [7:0]  e_dst;
    logic [7:0]  e_nrd;
    logic [7:0]  e_nwr;
    logic [7:0]  e_waddr;
    logic [31:0] e_wdata;
    logic [1:0]  e_wsize;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'd2, 3'd2, 1'b1, 1'b1, 1'b1, 8'h14, 8'h84, 8'd1, 8'd1, 8'h80, 32'h13121110, 2'd2},
    '{3'd0, 3'd2, 1'b1, 1'b1, 1'b0, 8'h14, 8'h81, 8'd4, 8'd1, 8'h80, 32'h13121110, 2'd2},
    '{3'd2, 3'd0, 1'b1, 1'b1, 1'b1, 8'h14, 8'h90, 8'd1, 8'd4, 8'h8F, 32'h00000013, 2'd0},
    '{3'd1, 3'd1, 1'b0, 1'b0, 1'b0, 8'h10, 8'h80, 8'd1, 8'd1, 8'h80, 32'h00001110, 2'd1},
    '{3'd7, 3'd5, 1'b1, 1'b0, 1'b1, 8'h14, 8'h80, 8'd1, 8'd1, 8'h80, 32'h13121110, 2'd2},
    '{3'd0, 3'd1, 1'b0, 1'b1, 1'b0, 8'h10, 8'h81, 8'd2, 8'd1, 8'h80, 32'h00001010, 2'd1}
  };

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int b_wr, b_rd, b_tc;
    logic [31:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 tc", {31'b0, tc_pulse}, 32'd0);
    chk("R1 req_valid", {31'b0, mem_req_valid}, 32'd0);
    chk("R1 host_ready", {31'b0, host_ready}, 32'd1);
    chk("R1 regs", src_addr | dst_addr | lli_addr | ctrl_word | cfg_word, 32'd0);

    // R3 grant ignored when disabled, then with zero count
    setup(32'h10, 32'h80, 32'h0, mk_ctrl(1'b0, 1'b1, 1'b1, 3'd2, 3'd2, 12'd1), 32'h0);
    do_grant();
    chk("R3 disabled grant ignored", {31'b0, busy}, 32'd0);
    host_wr(3'd3, mk_ctrl(1'b0, 1'b1, 1'b1, 3'd2, 3'd2, 12'd0));
    host_wr(3'd4, 32'h1);
    do_grant();
    chk("R3 zero count grant ignored", {31'b0, busy}, 32'd0);

    // R2 unknown select changes nothing
    host_wr(3'd5, 32'hDEAD_BEEF);
    chk("R2 sel5 src", src_addr, 32'h10);
    chk("R2 sel5 ctrl", ctrl_word, mk_ctrl(1'b0, 1'b1, 1'b1, 3'd2, 3'd2, 12'd0));
    chk("R2 sel5 cfg", cfg_word, 32'h1);

    // table of single-element transfers: R4 R5 R6 R7 R9 R10
    for (int i = 0; i < 6; i++) begin
      c = mk_ctrl(VECS[i].tc, VECS[i].di, VECS[i].si, VECS[i].dw, VECS[i].sw, 12'd1);
      setup(32'h10, 32'h80, 32'h0, c, 32'hF01);
      b_wr = nwr; b_rd = nrd; b_tc = ntc;
      do_grant();
      wait_idle();
      chk($sformatf("R5 v%0d src", i), src_addr, {24'b0, VECS[i].e_src});
      chk($sformatf("R5 v%0d reads", i), nrd - b_rd, {24'b0, VECS[i].e_nrd});
      chk($sformatf("R6 v%0d dst", i), dst_addr, {24'b0, VECS[i].e_dst});
      chk($sformatf("R6 v%0d writes", i), nwr - b_wr, {24'b0, VECS[i].e_nwr});
      chk($sformatf("R6 v%0d last waddr", i), wr_addr[(nwr - 1) % 256], {24'b0, VECS[i].e_waddr});
      chk($sformatf("R6 v%0d last wdata", i), wr_data[(nwr - 1) % 256], VECS[i].e_wdata);
      chk($sformatf("R4 v%0d wsize", i), {30'b0, wr_size[(nwr - 1) % 256]}, {30'b0, VECS[i].e_wsize});
      chk($sformatf("R4 v%0d rsize", i), {30'b0, rd_size[(nrd - 1) % 256]},
          {30'b0, (VECS[i].sw > 3'd2) ? 2'd2 : VECS[i].sw[1:0]});
      chk($sformatf("R7 v%0d ctrl", i), ctrl_word, c & 32'hFFFF_F000);
      chk($sformatf("R9 v%0d cfg", i), cfg_word, 32'hF00);
      chk($sformatf("R10 v%0d tc", i), ntc - b_tc, {31'b0, VECS[i].tc});
    end

    // R7 R10 R12 R2: two-element count, host write stalled mid-element
    c = mk_ctrl(1'b1, 1'b1, 1'b1, 3'd2, 3'd2, 12'd2);
    setup(32'h10, 32'h80, 32'h0, c, 32'h1);
    b_tc = ntc;
    do_grant();
    chk("R12 busy after grant", {31'b0, busy}, 32'd1);
    chk("R2 host_ready low while busy", {31'b0, host_ready}, 32'd0);
    host_wr(3'd2, 32'h77);
    wait_idle();
    chk("R2 write while busy ignored", lli_addr, 32'h0);
    chk("R7 count 2->1", ctrl_word, {c[31:12], 12'd1});
    chk("R9 enable kept mid-transfer", cfg_word, 32'h1);
    chk("R10 no tc on non-final element", ntc - b_tc, 32'd0);
    do_grant();
    wait_idle();
    chk("R5 second element src", src_addr, 32'h18);
    chk("R6 second element dst", dst_addr, 32'h88);
    chk("R9 final clears enable", cfg_word, 32'h0);
    chk("R10 tc on final element", ntc - b_tc, 32'd1);

    // R8 R10 R11: descriptor fetch
    setup(32'h10, 32'h80, 32'h40, mk_ctrl(1'b0, 1'b1, 1'b1, 3'd2, 3'd2, 12'd1), 32'h1);
    b_rd = nrd; b_tc = ntc;
    do_grant();
    wait_idle();
    chk("R8 fetch count", nrd - b_rd, 32'd5);
    chk("R8 fetch addr 0", rd_addr[(b_rd + 1) % 256], 32'h40);
    chk("R8 fetch addr 1", rd_addr[(b_rd + 2) % 256], 32'h44);
    chk("R8 fetch addr 2", rd_addr[(b_rd + 3) % 256], 32'h4C);
    chk("R8 fetch addr 3", rd_addr[(b_rd + 4) % 256], 32'h48);
    chk("R8 fetch size word", {30'b0, rd_size[(b_rd + 4) % 256]}, 32'd2);
    chk("R8 src loaded", src_addr, 32'h20);
    chk("R8 dst loaded", dst_addr, 32'hA0);
    chk("R8 ctrl loaded", ctrl_word, DESC_CTRL);
    chk("R8 lli loaded", lli_addr, 32'h0);
    chk("R9 enable kept after load", cfg_word, 32'h1);
    chk("R10 tc from fetched ctrl", ntc - b_tc, 32'd1);
    b_wr = nwr;
    do_grant();
    wait_idle();
    chk("R11 next element write addr", wr_addr[b_wr % 256], 32'hA0);
    chk("R11 next element write data", wr_data[b_wr % 256], 32'h23222120);
    chk("R9 list end clears enable", cfg_word, 32'h0);
    chk("R10 tc at list end", ntc - b_tc, 32'd2);

    // R3: host write and grant in the same idle cycle
    setup(32'h10, 32'h80, 32'h0, mk_ctrl(1'b0, 1'b0, 1'b0, 3'd2, 3'd2, 12'd1), 32'h1);
    b_rd = nrd;
    @(negedge clk);
    host_we = 1'b1; host_sel = 3'd0; host_wdata = 32'h30; grant = 1'b1;
    @(negedge clk);
    host_we = 1'b0; grant = 1'b0;
    chk("R12 busy after same-cycle grant", {31'b0, busy}, 32'd1);
    wait_idle();
    chk("R3 first read uses new src", rd_addr[b_rd % 256], 32'h30);

    finish_run();
  end

endmodule